// File: doc/BRIEF.md
# Settled Averaging Sweep Controller for a Multichannel ADC

This block runs one measurement sweep over a bank of differential ADC channels after a test fixture is switched from its heating path to its measurement path. A trigger in the idle state raises the fixture switch command. The block then holds off for a fixed number of clock cycles so that the switch contacts settle. After that it runs a burst of conversions on each channel in turn. The ADC itself sits outside the block, behind a simple start/busy/data handshake.

The samples of each burst are summed in an accumulator that is three bits wider than the data. The sum is shifted right to form the channel average, and the average is written into a per-channel result register. When the last channel has been stored, the block drops the switch command and pulses a done flag. Results can be read at any time through a combinational select port, and they hold until the next sweep overwrites them.

The sequence is a single state machine with these states:

- IDLE: waits for a trigger.
- SETTLE: holds the switch command while the settle timer runs.
- START: issues a one-cycle conversion request.
- WAIT: waits for the ADC to go idle and captures the sample.
- STORE: writes the channel average and moves to the next channel.
- DONE: pulses the done flag for one cycle.

The transitions are:

- IDLE→SETTLE on trigger.
- SETTLE→START when the timer expires.
- START→WAIT always.
- WAIT→START after a capture that is not the last of the burst.
- WAIT→STORE after the last capture of the burst.
- STORE→START when channels remain.
- STORE→DONE after the last channel.
- DONE→IDLE always.

Top module: `avg_adc_seq`

## Requirements
- R1: After reset, `meas_sw`, `adc_start` and `done` are low, and every result register reads 0.
- R2: A trigger sampled in IDLE raises `meas_sw` on the next cycle. Exactly SETTLE_CYC cycles (default 40) pass with `meas_sw` high and `adc_start` low before the first `adc_start`.
- R3: Each channel result equals floor(sum of its 8 samples / 8). The sum is kept in a 19-bit accumulator and never overflows, including when all samples are 0xFFFF.
- R4: `adc_start` is a one-cycle pulse. A sweep issues exactly NUM_CH×8 starts (default 128). The sample is taken from `adc_data` in the first cycle after a start in which `adc_busy` is low, and only then is the next start issued.
- R5: Channels are converted in ascending order from 0 to NUM_CH−1. The 8 conversions of one channel are consecutive, and the result for channel c is written after its eighth sample.
- R6: `done` is high for exactly one cycle, immediately after the last channel is stored. `meas_sw` is low in that cycle, and all results are readable then.
- R7: A trigger raised while a sweep is running has no effect: no further starts follow, and `meas_sw` stays low after `done`.
- R8: `rd_data` shows the result register chosen by `rd_sel` in the same cycle, and that value holds unchanged between sweeps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| trig | input | 1 | Sweep request, honoured only in IDLE |
| meas_sw | output | 1 | Fixture switch command, high for the whole sweep |
| adc_start | output | 1 | One-cycle conversion request |
| adc_busy | input | 1 | ADC conversion in progress |
| adc_data | input | 16 | Conversion result, valid when busy is low after a start |
| done | output | 1 | One-cycle sweep-complete pulse |
| rd_sel | input | 4 | Result register select |
| rd_data | output | 16 | Selected channel average |

## Verification
The assertions assume that the ADC raises `adc_busy` in the cycle right after it sees `adc_start`. They also assume that `adc_data` carries the new sample from the cycle in which busy falls. The bench's ADC model honours both. It sets the data word to a poison value while busy, so any early capture corrupts the averages, and it varies the conversion length between sweeps. Triggers are sent either in IDLE or deliberately in the middle of a sweep, never in the reset cycle.

// File: rtl/avg_adc_pkg.sv
package avg_adc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_START,
        ST_WAIT,
        ST_STORE,
        ST_DONE
    } seq_state_t;
endpackage

// File: rtl/avg_settle_timer.sv
module avg_settle_timer #(
    parameter int LIMIT = 40
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expired
);
    localparam int CW = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run)
            cnt_q <= '0;
        else if (!expired)
            cnt_q <= cnt_q + 1'b1;
    end

    assign expired = run && (cnt_q == LAST);

    // R2: the count never runs past the settle window
    p_settle_cap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= LAST);
endmodule

// File: rtl/avg_accum.sv
module avg_accum #(
    parameter int DATA_W   = 16,
    parameter int AVG_LOG2 = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              add_en,
    input  logic              first,
    input  logic [DATA_W-1:0] din,
    output logic [DATA_W-1:0] avg
);
    localparam int ACC_W = DATA_W + AVG_LOG2;

    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   wide_sum;

    assign wide_sum = {1'b0, acc_q} + (ACC_W + 1)'(din);

    always_ff @(posedge clk) begin
        if (!rst_n)
            acc_q <= '0;
        else if (add_en)
            acc_q <= first ? ACC_W'(din) : wide_sum[ACC_W-1:0];
    end

    assign avg = acc_q[ACC_W-1:AVG_LOG2];

    // R3: a burst never carries out of the accumulator
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (add_en && !first) |-> !wide_sum[ACC_W]);
endmodule

// File: rtl/avg_result_bank.sv
module avg_result_bank #(
    parameter int NUM_CH = 16,
    parameter int DATA_W = 16
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      wr_en,
    input  logic [$clog2(NUM_CH)-1:0] wr_sel,
    input  logic [DATA_W-1:0]         wr_data,
    input  logic [$clog2(NUM_CH)-1:0] rd_sel,
    output logic [DATA_W-1:0]         rd_data
);
    logic [NUM_CH-1:0][DATA_W-1:0] regs_q;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                regs_q[g] <= '0;
            else if (wr_en && (wr_sel == g))
                regs_q[g] <= wr_data;
        end
    end

    assign rd_data = regs_q[rd_sel];
endmodule

// File: rtl/avg_adc_seq.sv
module avg_adc_seq
    import avg_adc_pkg::*;
#(
    parameter int NUM_CH     = 16,
    parameter int DATA_W     = 16,
    parameter int AVG_LOG2   = 3,
    parameter int SETTLE_CYC = 40
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      trig,
    output logic                      meas_sw,
    output logic                      adc_start,
    input  logic                      adc_busy,
    input  logic [DATA_W-1:0]         adc_data,
    output logic                      done,
    input  logic [$clog2(NUM_CH)-1:0] rd_sel,
    output logic [DATA_W-1:0]         rd_data
);
    localparam int CH_W = $clog2(NUM_CH);
    localparam logic [CH_W-1:0]     LAST_CH   = CH_W'(NUM_CH - 1);
    localparam logic [AVG_LOG2-1:0] LAST_SAMP = '1;

    seq_state_t state_q, state_d;
    logic [CH_W-1:0]     ch_q;
    logic [AVG_LOG2-1:0] samp_q;
    logic settle_run, settle_done, capture, store;
    logic [DATA_W-1:0] avg;

    assign settle_run = (state_q == ST_SETTLE);
    assign capture    = (state_q == ST_WAIT) && !adc_busy;
    assign store      = (state_q == ST_STORE);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (trig) state_d = ST_SETTLE;
            ST_SETTLE: if (settle_done) state_d = ST_START;
            ST_START:  state_d = ST_WAIT;
            ST_WAIT:   if (!adc_busy) state_d = (samp_q == LAST_SAMP) ? ST_STORE : ST_START;
            ST_STORE:  state_d = (ch_q == LAST_CH) ? ST_DONE : ST_START;
            ST_DONE:   state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        meas_sw   = 1'b0;
        adc_start = 1'b0;
        done      = 1'b0;
        unique case (state_q)
            ST_SETTLE, ST_WAIT, ST_STORE: meas_sw = 1'b1;
            ST_START: begin
                meas_sw   = 1'b1;
                adc_start = 1'b1;
            end
            ST_DONE:  done = 1'b1;
            default:  ;
        endcase
    end

    // channel and sample counters
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_q   <= '0;
            samp_q <= '0;
        end else if (state_q == ST_IDLE && trig) begin
            ch_q   <= '0;
            samp_q <= '0;
        end else begin
            if (capture)
                samp_q <= samp_q + 1'b1;
            if (store)
                ch_q <= (ch_q == LAST_CH) ? '0 : ch_q + 1'b1;
        end
    end

    avg_settle_timer #(.LIMIT(SETTLE_CYC)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (settle_run),
        .expired (settle_done)
    );

    avg_accum #(.DATA_W(DATA_W), .AVG_LOG2(AVG_LOG2)) u_acc (
        .clk    (clk),
        .rst_n  (rst_n),
        .add_en (capture),
        .first  (samp_q == '0),
        .din    (adc_data),
        .avg    (avg)
    );

    avg_result_bank #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (store),
        .wr_sel  (ch_q),
        .wr_data (avg),
        .rd_sel  (rd_sel),
        .rd_data (rd_data)
    );

    // R4: conversion request lasts one cycle
    p_start_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> !adc_start);
    // R4: input assumption, the ADC reports busy right after a request
    p_busy_follows_r4: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |=> adc_busy);
    // R2: no conversion without the fixture switched to measurement
    p_start_switched_r2: assert property (@(posedge clk) disable iff (!rst_n)
        adc_start |-> meas_sw);
    // R6: done is a single-cycle pulse
    p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R7: a trigger mid-sweep does not break the sweep
    p_trig_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_sw && trig) |=> (meas_sw || done));
endmodule

// File: tb/avg_adc_seq_test.sv
module avg_adc_seq_test;
    localparam int NCH = 16;
    localparam int NS  = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic trig = 1'b0;
    logic meas_sw, adc_start, done;
    logic adc_busy = 1'b0;
    logic [15:0] adc_data = 16'h0;
    logic [3:0]  rd_sel = 4'd0;
    logic [15:0] rd_data;

    int checks = 0;
    int errors = 0;
    int sweep_id = 0;
    int conv_len = 1;

    always #10 clk = ~clk;

    avg_adc_seq uut (
        .clk(clk), .rst_n(rst_n), .trig(trig), .meas_sw(meas_sw),
        .adc_start(adc_start), .adc_busy(adc_busy), .adc_data(adc_data),
        .done(done), .rd_sel(rd_sel), .rd_data(rd_data)
    );

    function automatic logic [15:0] sample_val(int sw, int ch, int s);
        case (sw)
            0: return 16'(ch * 4000 + s * 11 + 5);
            1: return 16'hFFFF;
            2: return 16'(ch * 4096 + s);
            default: return 16'((ch * s * 977 + 13 * ch + s) & 16'hFFFF);
        endcase
    endfunction

    function automatic int expect_avg(int sw, int ch);
        int sum = 0;
        for (int s = 0; s < NS; s++) sum += int'(sample_val(sw, ch, s));
        return sum / NS;
    endfunction

    // ADC model: busy the cycle after start, data poisoned until busy falls
    int nstart_m = 0;
    int pend = 0;
    int rem = 0;
    always @(posedge clk) begin
        if (!rst_n) begin
            adc_busy <= 1'b0;
            nstart_m <= 0;
        end else begin
            if (trig && !meas_sw) nstart_m <= 0;
            if (adc_start) begin
                adc_busy <= 1'b1;
                rem      <= conv_len;
                pend     <= nstart_m;
                nstart_m <= nstart_m + 1;
                adc_data <= 16'hDEAD;
            end else if (adc_busy) begin
                if (rem <= 1) begin
                    adc_busy <= 1'b0;
                    adc_data <= sample_val(sweep_id, pend / NS, pend % NS);
                end else
                    rem <= rem - 1;
            end
        end
    end

    // monitor on the falling edge
    int settle_cnt = 0, settle_first = -1, start_cnt = 0, done_cnt = 0, done_sw_bad = 0;
    bit first_seen = 0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (trig && !meas_sw) begin
                settle_cnt = 0; settle_first = -1; start_cnt = 0;
                done_cnt = 0; done_sw_bad = 0; first_seen = 0;
            end else begin
                if (adc_start) begin
                    start_cnt++;
                    if (!first_seen) begin
                        first_seen = 1;
                        settle_first = settle_cnt;
                    end
                end else if (meas_sw && !first_seen)
                    settle_cnt++;
                if (done) begin
                    done_cnt++;
                    if (meas_sw) done_sw_bad++;
                end
            end
        end
    end

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic check_results(int sw, string req);
        for (int c = 0; c < NCH; c++) begin
            rd_sel = 4'(c);
            #1;
            chk(int'(rd_data) == expect_avg(sw, c), req, int'(rd_data), expect_avg(sw, c));
        end
    endtask

    task automatic run_sweep(int sw, int clen, bit poke);
        int t = 0;
        sweep_id = sw;
        conv_len = clen;
        @(posedge clk); #2 trig = 1'b1;
        @(posedge clk); #2 trig = 1'b0;
        // R2: switch command up in the cycle after the trigger
        @(negedge clk);
        chk(meas_sw == 1'b1, "R2 meas_sw raised", int'(meas_sw), 1);
        while (!done && t < 20000) begin
            @(negedge clk);
            t++;
            if (poke && t == 150) trig = 1'b1;
            if (poke && t == 151) trig = 1'b0;
        end
        if (!done) begin
            chk(1'b0, "watchdog", t, 0);
            return;
        end
        chk(settle_first == 40, "R2 settle cycles", settle_first, 40);
        chk(start_cnt == NCH * NS, "R4 start count", start_cnt, NCH * NS);
        chk(meas_sw == 1'b0, "R6 meas_sw low at done", int'(meas_sw), 0);
        // R3 R5: ordered per-channel averages readable at done
        check_results(sw, "R3/R5 average");
        @(negedge clk);
        chk(done == 1'b0 && done_cnt == 1, "R6 done width", done_cnt, 1);
        chk(done_sw_bad == 0, "R6 switch during done", done_sw_bad, 0);
        repeat (60) @(negedge clk);
        // R7: nothing restarts after a mid-sweep trigger
        chk(start_cnt == NCH * NS && meas_sw == 1'b0, "R7 no restart", start_cnt, NCH * NS);
        // R8: results hold between sweeps
        rd_sel = 4'd0; #1;
        chk(int'(rd_data) == expect_avg(sw, 0), "R8 hold ch0", int'(rd_data), expect_avg(sw, 0));
        rd_sel = 4'd15; #1;
        chk(int'(rd_data) == expect_avg(sw, 15), "R8 hold ch15", int'(rd_data), expect_avg(sw, 15));
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(meas_sw == 1'b0, "R1 meas_sw", int'(meas_sw), 0);
        chk(adc_start == 1'b0, "R1 adc_start", int'(adc_start), 0);
        chk(done == 1'b0, "R1 done", int'(done), 0);
        for (int c = 0; c < NCH; c++) begin
            rd_sel = 4'(c);
            #1;
            chk(rd_data == 16'h0, "R1 result zero", int'(rd_data), 0);
        end
        run_sweep(0, 1, 1'b0);
        run_sweep(1, 3, 1'b0);   // R3 full scale
        run_sweep(2, 6, 1'b1);   // R3 truncation, R7 mid-sweep trigger
        run_sweep(3, 2, 1'b1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule